// File: doc/BRIEF.md
# Jump Subfunction Decoder with Privilege Gating

The block decodes the subfunction field of a 36-bit machine's multi-purpose jump opcode. It also decides whether the selected subfunction may run in the current processor mode. A 4-bit code arrives with a `start` pulse, together with three mode flags and an extended-section indicator:

- `mode_user` is the user-mode flag.
- `mode_uio` is the user I/O permission flag.
- `mode_pub` is the public flag.
- `ext_sect` marks execution from a non-zero section.

The result is a one-cycle strobe to the execution unit. That strobe is either one primary action, optionally paired with an interrupt-dismiss request, or a lone trap strobe for an unimplemented operation.

Some subfunctions need an operand from memory first: the two-word flag/PC restore, the PC-word exchange and the memory-indirect jump. For these, a two-state sequencer holds a fetch request. The strobes, including any interrupt dismiss, are released only after the memory side reports completion. A fault that the memory side reports during the fetch cancels the instruction without any strobe.

The sequencer states are:

- IDLE: accepts `start`.
- FETCH: holds `fetch_req`.

The transitions are:

- IDLE to FETCH on a legal fetching code.
- FETCH to FETCH while the fetch is outstanding.
- FETCH to IDLE on completion, which commits the held actions.
- FETCH to IDLE on a fault, which commits nothing.
- IDLE to IDLE in every other case. Immediate codes and traps are committed directly from IDLE.

Top module: `jmp_subfn_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every action strobe, `act_trap` and `fetch_req` are low.
- R2: With `start` high in IDLE, an immediate code is committed as a single-cycle strobe in the next cycle, with `fetch_req` staying low. The immediate codes and their strobes are:
  - 0: `act_jump`
  - 1: `act_clr_pub`
  - 2: `act_rst_flags`
  - 4: `act_halt`
  - 8 (010): `act_jump` + `act_dismiss`
  - 10 (012): `act_rst_flags` + `act_dismiss`
  - 12 (014): `act_save_flags`
- R3: Codes 3, 9 (011), 11 (013), 14 (016) and 15 (017) produce only `act_trap`, for one cycle, in the cycle after `start`.
- R4: Code 4 yields `act_halt` only when `mode_user`=0 and `mode_pub`=0. Otherwise it yields `act_trap`.
- R5: Codes 6, 7, 8 and 10 are allowed only in the following cases. Any other case yields `act_trap` and no fetch.
  - With `mode_user`=1, only if `mode_uio`=1.
  - With `mode_user`=0, only if `mode_pub`=0.
- R6: Codes 2 and 10 with `ext_sect`=1 yield `act_trap`.
- R7: The fetching codes are 5 (`act_dw_restore`), 6 (`act_dw_restore` + `act_dismiss`), 7 (`act_pcw_xchg` + `act_dismiss`) and 13 (015, `act_ind_jump`). When one of them is legal, `fetch_req` rises in the cycle after `start` and stays high until a cycle with `fetch_done` or `fetch_fault`. After `fetch_done`, the strobes appear for one cycle in the following cycle, and `fetch_req` falls.
- R8: `act_dismiss` for codes 6 and 7 is never asserted before the cycle following the fetch completion.
- R9: Code 12 asserts `act_save_flags` with `act_jump` low, so the PC simply advances.
- R10: `fetch_fault` while `fetch_req` is high returns the sequencer to IDLE in the next cycle, with no strobe. It takes priority over a simultaneous `fetch_done`.
- R11: `start` while `fetch_req` is high is ignored. `fetch_done` and `fetch_fault` are ignored in IDLE.
- R12: At most one primary action strobe is high in any cycle, and when `act_trap` is high all action strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction present in this cycle |
| code | input | 4 | Subfunction field |
| mode_user | input | 1 | User-mode flag |
| mode_uio | input | 1 | User I/O permission flag |
| mode_pub | input | 1 | Public flag |
| ext_sect | input | 1 | Executing from a non-zero section |
| fetch_done | input | 1 | Operand fetch completed |
| fetch_fault | input | 1 | Operand fetch faulted |
| fetch_req | output | 1 | Operand fetch requested (FETCH state) |
| act_jump | output | 1 | Jump to the effective address |
| act_clr_pub | output | 1 | Clear public and jump |
| act_rst_flags | output | 1 | Restore flags and jump |
| act_halt | output | 1 | Halt the processor |
| act_dw_restore | output | 1 | Load flags and PC from the fetched pair |
| act_pcw_xchg | output | 1 | Exchange the PC word |
| act_save_flags | output | 1 | Store flags, no jump |
| act_ind_jump | output | 1 | Jump to the fetched address |
| act_dismiss | output | 1 | Dismiss the current interrupt |
| act_trap | output | 1 | Unimplemented-operation trap |

## Verification
The hardest situations to reach are inside the FETCH state. They are a fault arriving in the same cycle as completion, and a second `start` arriving while a fetch is outstanding. Neither can happen unless a legal fetching code was accepted under a permitting mode.

To reach them, the stimulus sweeps all sixteen codes against all sixteen combinations of the mode flags and the section flag. For each combination it holds the completion back by zero to three cycles. During that wait it injects extra `start` pulses, and it repeats the sweep with fault pulses, some of them coinciding with completion. A behavioural model predicts every output on every cycle.

// File: rtl/jsd_pkg.sv
package jsd_pkg;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] C_JUMP    = CODE_W'(0);
    localparam logic [CODE_W-1:0] C_CLRPUB  = CODE_W'(1);
    localparam logic [CODE_W-1:0] C_RSTF    = CODE_W'(2);
    localparam logic [CODE_W-1:0] C_HALT    = CODE_W'(4);
    localparam logic [CODE_W-1:0] C_DWRST   = CODE_W'(5);
    localparam logic [CODE_W-1:0] C_DWDIS   = CODE_W'(6);
    localparam logic [CODE_W-1:0] C_PCWX    = CODE_W'(7);
    localparam logic [CODE_W-1:0] C_DISJMP  = CODE_W'(8);
    localparam logic [CODE_W-1:0] C_DISRST  = CODE_W'(10);
    localparam logic [CODE_W-1:0] C_SAVEF   = CODE_W'(12);
    localparam logic [CODE_W-1:0] C_INDJ    = CODE_W'(13);

    typedef struct packed {
        logic dismiss;
        logic ind_jump;
        logic save_flags;
        logic pcw_xchg;
        logic dw_restore;
        logic halt;
        logic rst_flags;
        logic clr_pub;
        logic jump;
    } act_t;

    localparam int ACT_W = $bits(act_t);

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_FETCH = 1'b1
    } seq_state_t;
endpackage

// File: rtl/jsd_classify.sv
module jsd_classify
    import jsd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              mode_user,
    input  logic              mode_uio,
    input  logic              mode_pub,
    input  logic              ext_sect,
    output act_t              act,
    output logic              trap,
    output logic              need_fetch
);
    logic kernel_ok;
    logic dismiss_ok;

    always_comb begin
        kernel_ok  = !mode_user && !mode_pub;
        dismiss_ok = mode_user ? mode_uio : !mode_pub;
    end

    always_comb begin
        act        = '0;
        trap       = 1'b0;
        need_fetch = 1'b0;
        unique case (code)
            C_JUMP:   act.jump = 1'b1;
            C_CLRPUB: act.clr_pub = 1'b1;
            C_RSTF: begin
                if (ext_sect) trap = 1'b1;
                else          act.rst_flags = 1'b1;
            end
            C_HALT: begin
                if (kernel_ok) act.halt = 1'b1;
                else           trap = 1'b1;
            end
            C_DWRST: begin
                act.dw_restore = 1'b1;
                need_fetch     = 1'b1;
            end
            C_DWDIS: begin
                if (dismiss_ok) begin
                    act.dw_restore = 1'b1;
                    act.dismiss    = 1'b1;
                    need_fetch     = 1'b1;
                end else begin
                    trap = 1'b1;
                end
            end
            C_PCWX: begin
                if (dismiss_ok) begin
                    act.pcw_xchg = 1'b1;
                    act.dismiss  = 1'b1;
                    need_fetch   = 1'b1;
                end else begin
                    trap = 1'b1;
                end
            end
            C_DISJMP: begin
                if (dismiss_ok) begin
                    act.jump    = 1'b1;
                    act.dismiss = 1'b1;
                end else begin
                    trap = 1'b1;
                end
            end
            C_DISRST: begin
                if (ext_sect || !dismiss_ok) begin
                    trap = 1'b1;
                end else begin
                    act.rst_flags = 1'b1;
                    act.dismiss   = 1'b1;
                end
            end
            C_SAVEF:  act.save_flags = 1'b1;
            C_INDJ: begin
                act.ind_jump = 1'b1;
                need_fetch   = 1'b1;
            end
            default:  trap = 1'b1;
        endcase
    end
endmodule

// File: rtl/jsd_seq.sv
module jsd_seq
    import jsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  act_t dec_act,
    input  logic dec_trap,
    input  logic dec_fetch,
    input  logic fetch_done,
    input  logic fetch_fault,
    output logic fetch_req,
    output act_t act_q,
    output logic trap_q
);
    seq_state_t state, state_nx;
    act_t       pend_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start && !dec_trap && dec_fetch) state_nx = S_FETCH;
            end
            S_FETCH: begin
                if (fetch_fault || fetch_done) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            trap_q <= 1'b0;
            pend_q <= '0;
        end else begin
            act_q  <= '0;
            trap_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        if (dec_trap)       trap_q <= 1'b1;
                        else if (dec_fetch) pend_q <= dec_act;
                        else                act_q  <= dec_act;
                    end
                end
                S_FETCH: begin
                    if (!fetch_fault && fetch_done) act_q <= pend_q;
                end
                default: ;
            endcase
        end
    end

    assign fetch_req = (state == S_FETCH);
endmodule

// File: rtl/jmp_subfn_decoder.sv
module jmp_subfn_decoder
    import jsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    input  logic              mode_user,
    input  logic              mode_uio,
    input  logic              mode_pub,
    input  logic              ext_sect,
    input  logic              fetch_done,
    input  logic              fetch_fault,
    output logic              fetch_req,
    output logic              act_jump,
    output logic              act_clr_pub,
    output logic              act_rst_flags,
    output logic              act_halt,
    output logic              act_dw_restore,
    output logic              act_pcw_xchg,
    output logic              act_save_flags,
    output logic              act_ind_jump,
    output logic              act_dismiss,
    output logic              act_trap
);
    act_t dec_act;
    logic dec_trap;
    logic dec_fetch;
    act_t act_q;
    logic trap_q;

    jsd_classify u_cls (
        .code       (code),
        .mode_user  (mode_user),
        .mode_uio   (mode_uio),
        .mode_pub   (mode_pub),
        .ext_sect   (ext_sect),
        .act        (dec_act),
        .trap       (dec_trap),
        .need_fetch (dec_fetch)
    );

    jsd_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dec_act     (dec_act),
        .dec_trap    (dec_trap),
        .dec_fetch   (dec_fetch),
        .fetch_done  (fetch_done),
        .fetch_fault (fetch_fault),
        .fetch_req   (fetch_req),
        .act_q       (act_q),
        .trap_q      (trap_q)
    );

    assign act_jump       = act_q.jump;
    assign act_clr_pub    = act_q.clr_pub;
    assign act_rst_flags  = act_q.rst_flags;
    assign act_halt       = act_q.halt;
    assign act_dw_restore = act_q.dw_restore;
    assign act_pcw_xchg   = act_q.pcw_xchg;
    assign act_save_flags = act_q.save_flags;
    assign act_ind_jump   = act_q.ind_jump;
    assign act_dismiss    = act_q.dismiss;
    assign act_trap       = trap_q;
endmodule

// File: rtl/jsd_chk.sv
module jsd_chk (
    input logic clk,
    input logic rst_n,
    input logic fetch_done,
    input logic fetch_fault,
    input logic mode_user,
    input logic mode_pub,
    input logic fetch_req,
    input logic act_jump,
    input logic act_clr_pub,
    input logic act_rst_flags,
    input logic act_halt,
    input logic act_dw_restore,
    input logic act_pcw_xchg,
    input logic act_save_flags,
    input logic act_ind_jump,
    input logic act_dismiss,
    input logic act_trap
);
    logic [7:0] prim;
    logic       any_act;

    assign prim = {act_jump, act_clr_pub, act_rst_flags, act_halt,
                   act_dw_restore, act_pcw_xchg, act_save_flags, act_ind_jump};
    assign any_act = (|prim) || act_dismiss;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!any_act && !act_trap && !fetch_req));

    p_onehot_prim_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prim));

    p_trap_alone_r12: assert property (@(posedge clk) disable iff (!rst_n)
        act_trap |-> !any_act);

    p_halt_kernel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_halt |-> $past(!mode_user && !mode_pub));

    p_fetch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_done && !fetch_fault) |=> fetch_req);

    p_dismiss_after_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_dismiss && (act_dw_restore || act_pcw_xchg)) |->
            $past(fetch_req && fetch_done && !fetch_fault));

    p_save_nojump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act_save_flags |-> !act_jump);

    p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_fault) |=> (!any_act && !act_trap && !fetch_req));
endmodule

bind jmp_subfn_decoder jsd_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_done     (fetch_done),
    .fetch_fault    (fetch_fault),
    .mode_user      (mode_user),
    .mode_pub       (mode_pub),
    .fetch_req      (fetch_req),
    .act_jump       (act_jump),
    .act_clr_pub    (act_clr_pub),
    .act_rst_flags  (act_rst_flags),
    .act_halt       (act_halt),
    .act_dw_restore (act_dw_restore),
    .act_pcw_xchg   (act_pcw_xchg),
    .act_save_flags (act_save_flags),
    .act_ind_jump   (act_ind_jump),
    .act_dismiss    (act_dismiss),
    .act_trap       (act_trap)
);

// File: tb/jmp_subfn_decoder_tb.sv
module jmp_subfn_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] code = 4'd0;
    logic       mode_user = 1'b0, mode_uio = 1'b0, mode_pub = 1'b0, ext_sect = 1'b0;
    logic       fetch_done = 1'b0, fetch_fault = 1'b0;
    logic       fetch_req;
    logic       act_jump, act_clr_pub, act_rst_flags, act_halt, act_dw_restore;
    logic       act_pcw_xchg, act_save_flags, act_ind_jump, act_dismiss, act_trap;

    localparam int B_J = 1, B_CLR = 2, B_RST = 4, B_HALT = 8, B_DWR = 16;
    localparam int B_PCW = 32, B_SAVE = 64, B_IND = 128, B_DIS = 256, B_TRAP = 512;

    int    checks = 0;
    int    bad = 0;
    int    cyc = 0;
    int    e_out = 0;
    bit    e_fetch = 0;
    int    m_pend = 0;
    string m_tag = "R1";

    always #10 clk = ~clk;

    jmp_subfn_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .code(code),
        .mode_user(mode_user), .mode_uio(mode_uio), .mode_pub(mode_pub),
        .ext_sect(ext_sect), .fetch_done(fetch_done), .fetch_fault(fetch_fault),
        .fetch_req(fetch_req), .act_jump(act_jump), .act_clr_pub(act_clr_pub),
        .act_rst_flags(act_rst_flags), .act_halt(act_halt),
        .act_dw_restore(act_dw_restore), .act_pcw_xchg(act_pcw_xchg),
        .act_save_flags(act_save_flags), .act_ind_jump(act_ind_jump),
        .act_dismiss(act_dismiss), .act_trap(act_trap)
    );

    // Behavioural reference: what the requirements say a code should produce.
    task automatic ref_decode(input int c, input bit u, input bit io, input bit p,
                              input bit x, output int res, output bit fet,
                              output string tg);
        bit kern;
        bit dis_ok;
        kern   = !u && !p;
        dis_ok = u ? io : !p;
        fet    = 0;
        res    = 0;
        tg     = "R2";
        if (c == 3 || c == 9 || c == 11 || c == 14 || c == 15) begin
            res = B_TRAP; tg = "R3";
        end else if ((c == 2 || c == 10) && x) begin
            res = B_TRAP; tg = "R6";
        end else if (c == 4) begin
            res = kern ? B_HALT : B_TRAP; tg = "R4";
        end else if (c == 6 || c == 7 || c == 8 || c == 10) begin
            if (!dis_ok) begin
                res = B_TRAP; tg = "R5";
            end else begin
                tg = "R5";
                if (c == 6) begin res = B_DWR | B_DIS; fet = 1; tg = "R8"; end
                if (c == 7) begin res = B_PCW | B_DIS; fet = 1; tg = "R8"; end
                if (c == 8) res = B_J | B_DIS;
                if (c == 10) res = B_RST | B_DIS;
            end
        end else if (c == 5) begin
            res = B_DWR; fet = 1; tg = "R7";
        end else if (c == 13) begin
            res = B_IND; fet = 1; tg = "R7";
        end else if (c == 12) begin
            res = B_SAVE; tg = "R9";
        end else if (c == 0) begin
            res = B_J;
        end else if (c == 1) begin
            res = B_CLR;
        end else begin
            res = B_RST;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_out = 0; e_fetch = 0; m_pend = 0; m_tag = "R1";
        end else begin
            int  nxt;
            int  r;
            bit  f;
            string t;
            nxt = 0;
            if (e_fetch) begin
                if (fetch_fault) begin
                    e_fetch = 0; m_tag = "R10";
                end else if (fetch_done) begin
                    nxt = m_pend; e_fetch = 0;
                    m_tag = ((m_pend & B_DIS) != 0) ? "R8" : "R7";
                end else begin
                    m_tag = start ? "R11" : "R7";
                end
            end else if (start) begin
                ref_decode(int'(code), mode_user, mode_uio, mode_pub, ext_sect, r, f, t);
                m_tag = t;
                if (r == B_TRAP) nxt = r;
                else if (f) begin e_fetch = 1; m_pend = r; end
                else nxt = r;
            end else begin
                m_tag = (fetch_done || fetch_fault) ? "R11" : "R12";
            end
            e_out = nxt;
        end
    end

    always @(negedge clk) begin
        int act;
        act = {22'd0, act_trap, act_dismiss, act_ind_jump, act_save_flags,
               act_pcw_xchg, act_dw_restore, act_halt, act_rst_flags,
               act_clr_pub, act_jump};
        checks++;
        if (act !== e_out || fetch_req !== e_fetch) begin
            bad++;
            $display("FAIL %s cyc=%0d actual act=%h fetch=%b expected act=%h fetch=%b",
                     m_tag, cyc, act, fetch_req, e_out, e_fetch);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic run_op(input int c, input int flags, input int dly,
                          input bit with_fault, input bit both, input bit extra);
        @(negedge clk);
        code = c[3:0];
        {mode_user, mode_uio, mode_pub, ext_sect} = flags[3:0];
        start = 1;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < dly; i++) begin
            if (extra) begin start = 1; code = 4'd0; end
            @(negedge clk);
            start = 0;
        end
        fetch_fault = with_fault;
        fetch_done  = !with_fault || both;
        @(negedge clk);
        fetch_done = 0; fetch_fault = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        for (int c = 0; c < 16; c++)
            for (int fl = 0; fl < 16; fl++)
                run_op(c, fl, (c + fl) % 4, 0, 0, (fl % 3) == 0);
        for (int c = 5; c < 14; c++)
            for (int fl = 0; fl < 16; fl++)
                run_op(c, fl, fl % 3, 1, (fl % 2) == 1, 0);
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule